// File: doc/BRIEF.md
# Codeword Marker Lock Detector

This block watches a received single-lane stream that a forward error correction decoder will later consume. At every codeword boundary the upstream logic shows one 64-bit candidate word and raises a strobe. The block scores the candidate against a known marker payload by nibbles. It then runs a lock machine that confirms markers return at a fixed codeword spacing.

Once locked, the block flags every expected marker slot so that downstream logic can strip the marker out of the data. A match pulse reports every candidate that passed the nibble test. A small run counter shows how many expected slots in a row have held no valid marker.

The marker pattern, the mask of known bits, the spacing, the mismatch tolerance and the miss limit are all parameters.

Top module: `cwm_lock_top`

## Requirements
- R1: A strobed candidate counts as a marker when at most MAX_BAD (3) of its known nibbles differ from the pattern. A nibble differs when any of its known bits differs. When it counts, `mark_ok` pulses high in the cycle after the strobe.
- R2: Bits [31:24] and [63:56] of the candidate are variable fill. Their value never affects the match result.
- R3: With default parameters, the expected pattern is as follows: bytes 0x90, 0x76, 0x47 in bits [7:0], [15:8], [23:16], and bytes 0x6F, 0x89, 0xB8 in bits [39:32], [47:40], [55:48].
- R4: While hunting, every strobe is tested as a possible first marker. A match arms the machine and restarts the spacing count at that boundary.
- R5: When armed, the strobe exactly GAP strobes after the first marker is the expected slot. A match there sets `locked` in the next cycle. A miss there returns the machine to hunting.
- R6: While armed or locked, strobes that are not at the expected slot leave the state, `locked` and `miss_run` unchanged, whatever they carry.
- R7: While locked, a miss at an expected slot raises `miss_run` by one and keeps `locked`. A match at an expected slot clears `miss_run` to 0.
- R8: MISS_LIMIT (3) consecutive misses at expected slots clear `locked` and `miss_run` in the cycle after the third miss. The machine then hunts again.
- R9: `mark_at` pulses for one cycle after each expected-slot strobe while locked, including the slot that drops lock. It also pulses after the slot whose marker brings lock.
- R10: After synchronous reset, `locked`, `mark_ok` and `mark_at` are 0 and `miss_run` is 0.
- R11: In a cycle without strobe, the candidate word is ignored. No pulse follows and the state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_stb | input | 1 | Codeword boundary strobe; qualifies `cw_word` |
| cw_word | input | 64 | Candidate marker payload |
| locked | output | 1 | Marker lock held |
| mark_ok | output | 1 | Previous strobed candidate passed the nibble test |
| mark_at | output | 1 | Previous strobe was an expected marker slot to remove |
| miss_run | output | $clog2(MISS_LIMIT+1) | Consecutive misses at expected slots while locked |

## Verification
The lock decision and the removal strobe meet in one cycle. At the expected slot that completes lock, `mark_ok`, `mark_at` and the rise of `locked` must all appear together. At the third consecutive miss, `mark_at` must still pulse in the same cycle that `locked` falls.

The bench provokes both cases by placing tolerant markers (up to three corrupted nibbles, random fill bytes) and four-nibble failures exactly on the expected slot. It also places valid markers off the slot, between idle cycles. A behavioural model predicts all four outputs each clock, and the bench compares them on the following falling edge.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOCK  = 2'd2
    } lock_st_e;

    typedef struct packed {
        logic [4:0] bad;
        logic       hit;
    } cand_res_t;

    localparam int WORD_W = 64;
    localparam int NIB_N  = WORD_W / 4;

    // Lane 0 marker, first transmitted byte in the low bits.
    localparam logic [WORD_W-1:0] LANE0_PAT   = 64'h00B8_896F_0047_7690;
    localparam logic [WORD_W-1:0] LANE0_KNOWN = 64'h00FF_FFFF_00FF_FFFF;

    function automatic logic [4:0] pop16(input logic [NIB_N-1:0] v);
        logic [4:0] n;
        n = '0;
        for (int i = 0; i < NIB_N; i++) begin
            n = n + {4'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/cwm_nib_match.sv
module cwm_nib_match
    import cwm_pkg::*;
#(
    parameter logic [WORD_W-1:0] PAT     = LANE0_PAT,
    parameter logic [WORD_W-1:0] KNOWN   = LANE0_KNOWN,
    parameter int                MAX_BAD = 3
) (
    input  logic [WORD_W-1:0] word,
    output cand_res_t         res
);

    logic [NIB_N-1:0] nib_diff;

    for (genvar g = 0; g < NIB_N; g++) begin : g_nib
        assign nib_diff[g] = |((word[g*4 +: 4] ^ PAT[g*4 +: 4]) & KNOWN[g*4 +: 4]);
    end

    always_comb begin
        res.bad = pop16(nib_diff);
        res.hit = (res.bad <= 5'(MAX_BAD));
    end

endmodule

// File: rtl/cwm_gap_ctr.sv
module cwm_gap_ctr #(
    parameter int GAP = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic restart,
    output logic at_exp
);

    localparam int CW = (GAP > 2) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] LAST = CW'(GAP - 1);

    logic [CW-1:0] cnt;

    assign at_exp = stb && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (stb) begin
            if (restart || cnt == LAST) cnt <= '0;
            else                        cnt <= cnt + 1'b1;
        end
    end

    // R4: spacing count never passes the last slot index
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/cwm_lock_fsm.sv
module cwm_lock_fsm
    import cwm_pkg::*;
#(
    parameter int MISS_LIMIT = 3,
    localparam int MW = $clog2(MISS_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic          hit,
    input  logic          at_exp,
    output logic          restart,
    output logic          locked,
    output logic          mark_ok,
    output logic          mark_at,
    output logic [MW-1:0] miss_run
);

    lock_st_e st, st_nx;
    logic [MW-1:0] miss_nx;
    logic          at_nx;

    assign restart = stb && (st == ST_HUNT) && hit;
    assign locked  = (st == ST_LOCK);

    always_comb begin
        st_nx   = st;
        miss_nx = miss_run;
        at_nx   = 1'b0;
        if (stb) begin
            unique case (st)
                ST_HUNT: begin
                    if (hit) st_nx = ST_ARMED;
                end
                ST_ARMED: begin
                    if (at_exp) begin
                        if (hit) begin
                            st_nx   = ST_LOCK;
                            miss_nx = '0;
                            at_nx   = 1'b1;
                        end else begin
                            st_nx = ST_HUNT;
                        end
                    end
                end
                ST_LOCK: begin
                    if (at_exp) begin
                        at_nx = 1'b1;
                        if (hit) begin
                            miss_nx = '0;
                        end else if (miss_run == MW'(MISS_LIMIT - 1)) begin
                            miss_nx = '0;
                            st_nx   = ST_HUNT;
                        end else begin
                            miss_nx = miss_run + 1'b1;
                        end
                    end
                end
                default: st_nx = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_HUNT;
            miss_run <= '0;
            mark_ok  <= 1'b0;
            mark_at  <= 1'b0;
        end else begin
            st       <= st_nx;
            miss_run <= miss_nx;
            mark_ok  <= stb && hit;
            mark_at  <= at_nx;
        end
    end

    // R5: lock only appears together with an accepted marker at its slot
    a_r5_lock_on_marker: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (mark_ok && mark_at));

    // R7: miss run stays below the limit
    a_r7_miss_bound: assert property (@(posedge clk) disable iff (rst)
        miss_run < MW'(MISS_LIMIT));

    // R8: lock falls only at a missed expected slot
    a_r8_drop_at_slot: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> (mark_at && !mark_ok));

    // R9: removal strobe only around a held lock
    a_r9_at_with_lock: assert property (@(posedge clk) disable iff (rst)
        mark_at |-> (locked || $past(locked)));

    // R11: a cycle without strobe changes nothing
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !stb |=> (!mark_ok && !mark_at && $stable(locked) && $stable(miss_run)));

endmodule

// File: rtl/cwm_lock_top.sv
module cwm_lock_top
    import cwm_pkg::*;
#(
    parameter logic [63:0] PAT        = LANE0_PAT,
    parameter logic [63:0] KNOWN      = LANE0_KNOWN,
    parameter int          MAX_BAD    = 3,
    parameter int          GAP        = 1024,
    parameter int          MISS_LIMIT = 3,
    localparam int         MW         = $clog2(MISS_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cw_stb,
    input  logic [63:0]   cw_word,
    output logic          locked,
    output logic          mark_ok,
    output logic          mark_at,
    output logic [MW-1:0] miss_run
);

    cand_res_t res;
    logic      restart;
    logic      at_exp;

    cwm_nib_match #(
        .PAT     (PAT),
        .KNOWN   (KNOWN),
        .MAX_BAD (MAX_BAD)
    ) u_match (
        .word (cw_word),
        .res  (res)
    );

    cwm_gap_ctr #(
        .GAP (GAP)
    ) u_gap (
        .clk     (clk),
        .rst     (rst),
        .stb     (cw_stb),
        .restart (restart),
        .at_exp  (at_exp)
    );

    cwm_lock_fsm #(
        .MISS_LIMIT (MISS_LIMIT)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .stb      (cw_stb),
        .hit      (res.hit),
        .at_exp   (at_exp),
        .restart  (restart),
        .locked   (locked),
        .mark_ok  (mark_ok),
        .mark_at  (mark_at),
        .miss_run (miss_run)
    );

    // R1: an accepted candidate always follows a strobe
    a_r1_ok_after_stb: assert property (@(posedge clk) disable iff (rst)
        mark_ok |-> $past(cw_stb));

endmodule

// File: tb/sim_cwm_lock_top.sv
module sim_cwm_lock_top;

    localparam int GAP = 8;
    localparam int LIM = 3;
    localparam logic [63:0] PAT = 64'h00B8_896F_0047_7690;

    logic        clk = 1'b0;
    logic        rst;
    logic        cw_stb;
    logic [63:0] cw_word;
    logic        locked, mark_ok, mark_at;
    logic [1:0]  miss_run;

    always #5 clk = ~clk;

    cwm_lock_top #(.GAP(GAP), .MISS_LIMIT(LIM)) u0 (
        .clk(clk), .rst(rst), .cw_stb(cw_stb), .cw_word(cw_word),
        .locked(locked), .mark_ok(mark_ok), .mark_at(mark_at), .miss_run(miss_run)
    );

    // reference model: 0 hunt, 1 armed, 2 locked
    int    m_st, m_pos, m_miss;
    bit    e_lock, e_ok, e_at;
    int    total = 0, bad = 0;
    string req = "R10";

    function automatic int bad_nibs(logic [63:0] w);
        int n = 0;
        for (int i = 0; i < 16; i++) begin
            if ((i % 8) < 6 && w[i*4 +: 4] != PAT[i*4 +: 4]) n++;
        end
        return n;
    endfunction

    function automatic logic [63:0] mk(int nbad);
        logic [63:0] w = PAT;
        w[31:24] = 8'($urandom);
        w[63:56] = 8'($urandom);
        for (int k = 0; k < nbad; k++) begin
            int idx = (k < 6) ? k : k + 2;
            w[idx*4 +: 4] = w[idx*4 +: 4] ^ 4'h5;
        end
        return w;
    endfunction

    function automatic logic [63:0] junk();
        return {$urandom, $urandom} ^ 64'h5A5A_0F0F_A5A5_F0F0;
    endfunction

    task automatic check();
        total++;
        if (locked !== e_lock || mark_ok !== e_ok || mark_at !== e_at ||
            int'(miss_run) != m_miss) begin
            bad++;
            $display("FAIL %s: act lock=%0b ok=%0b at=%0b miss=%0d exp lock=%0b ok=%0b at=%0b miss=%0d",
                     req, locked, mark_ok, mark_at, miss_run, e_lock, e_ok, e_at, m_miss);
        end
    endtask

    task automatic model(bit s, logic [63:0] w);
        bit v = (bad_nibs(w) <= 3);
        bit at_slot;
        e_ok = s && v;
        e_at = 1'b0;
        if (s) begin
            at_slot = (m_pos == GAP - 1);
            m_pos = at_slot ? 0 : m_pos + 1;
            if (m_st == 0) begin
                if (v) begin m_st = 1; m_pos = 0; end
            end else if (m_st == 1) begin
                if (at_slot) begin
                    if (v) begin m_st = 2; m_miss = 0; e_at = 1'b1; end
                    else   m_st = 0;
                end
            end else if (at_slot) begin
                e_at = 1'b1;
                if (v) m_miss = 0;
                else begin
                    m_miss++;
                    if (m_miss == LIM) begin m_miss = 0; m_st = 0; end
                end
            end
        end
        e_lock = (m_st == 2);
    endtask

    task automatic cyc(bit s, logic [63:0] w);
        @(negedge clk);
        check();
        cw_stb  = s;
        cw_word = w;
        model(s, w);
    endtask

    // seven non-slot strobes with idle gaps and stray markers (R6)
    task automatic fill();
        for (int i = 0; i < GAP - 1; i++) begin
            if (i % 3 == 1) cyc(1'b0, mk(0));
            cyc(1'b1, (i % 2 == 0) ? mk(0) : junk());
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: act=timeout exp=finish");
        summary();
    end

    initial begin
        rst = 1'b1; cw_stb = 1'b0; cw_word = '0;
        m_st = 0; m_pos = 0; m_miss = 0; e_lock = 0; e_ok = 0; e_at = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        req = "R10"; cyc(1'b0, '0);
        req = "R11"; for (int i = 0; i < 4; i++) cyc(1'b0, mk(0));
        req = "R1";  cyc(1'b1, mk(4)); cyc(1'b1, junk()); cyc(1'b1, junk());
        req = "R3";  cyc(1'b1, PAT);            // armed
        req = "R6";  fill();
        req = "R5";  cyc(1'b1, mk(2));          // lock
        req = "R9";  fill(); cyc(1'b1, mk(0));
        req = "R2";  fill(); cyc(1'b1, mk(3));
        req = "R7";  fill(); cyc(1'b1, mk(4));  // one miss
        fill(); cyc(1'b1, mk(1));               // cleared
        fill(); cyc(1'b1, junk());
        fill(); cyc(1'b1, mk(5));
        req = "R8";  fill(); cyc(1'b1, junk()); // drop
        cyc(1'b1, junk());
        req = "R4";  cyc(1'b1, mk(0));          // armed again
        req = "R5";  fill(); cyc(1'b1, mk(4));  // fails, hunt
        cyc(1'b1, junk());
        req = "R4";  cyc(1'b1, mk(1));
        req = "R5";  fill(); cyc(1'b1, mk(3));  // relock
        req = "R11"; for (int i = 0; i < 5; i++) cyc(1'b0, junk());
        req = "R9";  fill(); cyc(1'b1, mk(0));
        cyc(1'b0, '0);
        cyc(1'b0, '0);
        summary();
    end

endmodule